// File: doc/BRIEF.md
# Four-Pixel Regional Hit Buffer

This block is the shared digital logic behind a group of four neighbouring pixel discriminators: upper-left, lower-left, upper-right and lower-right. It runs on the bunch-crossing clock. For each pixel it measures how many clock samples the discriminator stays high, which gives a 4-bit time-over-threshold. Pixels that fire close together in time are grouped into one region event, and the event is time-stamped by its first leading edge. A short hit that starts while a larger neighbour is still above threshold joins that neighbour's event. Position therefore stands in for the timing that a time-walked small signal cannot give.

Kept events wait in a small pool of slots. Each slot carries a latency counter that started at the event's first leading edge. If the level-1 trigger arrives in the cycle when the counter equals the programmed latency, the slot is held and stamped with the trigger tag. Otherwise the slot is released. Held slots go to the column readout one at a time, under a token that passes between regions and a read strobe that frees the presented slot. Only triggered hits ever leave the region.

Top module: `pixreg_hit_buffer`

## Requirements
- R1: The discriminator inputs map as disc_i[0]=upper-left, [1]=lower-left, [2]=upper-right, [3]=lower-right. A pixel's ToT is the number of rising clock edges at which its input was sampled high, saturating at 15. The output packs it as data_tot_o[3:0]=upper-left, [7:4]=lower-left, [11:8]=upper-right, [15:12]=lower-right, and a pixel that did not fire reports 0.
- R2: A leading edge on a pixel joins the open event while at least one pixel already in the event is still sampled high. The event closes at the first edge where every member pixel is sampled low. A leading edge after that starts a new event with its own timestamp.
- R3: A closed event is stored only if at least one member has ToT of at least SMALL_TOT (3 by default). The small members of a stored event are kept with it. An event made only of small hits is discarded.
- R4: A stored event whose trigger input is sampled high exactly latency_i clock edges after its first leading edge becomes triggered and captures trig_tag_i. The latency may be changed between events.
- R5: A stored event that sees no trigger at that exact edge is released, and triggers at any other edge have no effect on it.
- R6: The pool has 5 slots. A stored event that closes while all slots are occupied is dropped, and overflow_o is high for one cycle after the closing edge.
- R7: data_valid_o is high only while token_in_i is high and a triggered slot exists. token_out_o equals token_in_i when no slot is triggered and is 0 otherwise.
- R8: read_i sampled high while data_valid_o is high frees the presented slot. Among triggered slots the lowest-numbered one is presented first, and slots fill from the lowest free index.
- R9: After reset no slot is occupied, data_valid_o and overflow_o are 0, and token_out_o follows token_in_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disc_i | input | 4 | Discriminator outputs of the four pixels |
| latency_i | input | LAT_W | Trigger latency in clock cycles |
| trig_i | input | 1 | Level-1 trigger strobe |
| trig_tag_i | input | TAG_W | Tag stored with a triggered event |
| token_in_i | input | 1 | Readout token from the preceding region |
| read_i | input | 1 | Read strobe that consumes the presented event |
| token_out_o | output | 1 | Readout token to the next region |
| data_valid_o | output | 1 | A triggered event is presented |
| data_tot_o | output | 16 | Packed ToT of the presented event |
| data_tag_o | output | TAG_W | Trigger tag of the presented event |
| overflow_o | output | 1 | One-cycle pulse for an event lost to a full pool |

## Verification
The bench builds the block with its defaults: five slots, 4-bit ToT, 8-bit latency and small-hit threshold 3. It programs latencies of 24 and 40 cycles. Those values leave room for a 17-cycle pulse to reach ToT saturation and close well before its trigger decision. Five slots let six back-to-back triggered events reach the overflow case within a few hundred cycles. The 4-bit tag makes each event of that sequence distinct, so the readout order can be checked.

// File: rtl/pixreg_pkg.sv
package pixreg_pkg;
   localparam int NPIX = 4;

   typedef enum logic [1:0] {
      SLOT_FREE = 2'd0,
      SLOT_WAIT = 2'd1,
      SLOT_TRIG = 2'd2
   } slot_state_e;
endpackage

// File: rtl/pixreg_tot_meas.sv
module pixreg_tot_meas #(
   parameter int TOT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             disc_i,
   input  logic             close_i,
   output logic             join_o,
   output logic             running_o,
   output logic             ends_o,
   output logic             joined_o,
   output logic [TOT_W-1:0] tot_o
);
   localparam logic [TOT_W-1:0] TOT_MAX = {TOT_W{1'b1}};

   logic             prev_q;
   logic             joined_q;
   logic             running_q;
   logic [TOT_W-1:0] tot_q;

   assign join_o    = disc_i & ~prev_q & ~joined_q;
   assign ends_o    = running_q & ~disc_i;
   assign running_o = running_q;
   assign joined_o  = joined_q;
   assign tot_o     = tot_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q    <= 1'b0;
         joined_q  <= 1'b0;
         running_q <= 1'b0;
         tot_q     <= '0;
      end else begin
         prev_q <= disc_i;
         if (join_o) begin
            joined_q  <= 1'b1;
            running_q <= 1'b1;
            tot_q     <= TOT_W'(1);
         end else begin
            if (running_q) begin
               if (disc_i) begin
                  if (tot_q != TOT_MAX) tot_q <= tot_q + TOT_W'(1);
               end else begin
                  running_q <= 1'b0;
               end
            end
            if (close_i) joined_q <= 1'b0;
         end
      end
   end

   // R1: a measurement stops only on a low sample
   assert_tot_stop_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running_q) |-> $past(!disc_i));
endmodule

// File: rtl/pixreg_event_track.sv
module pixreg_event_track
   import pixreg_pkg::*;
#(
   parameter int TOT_W     = 4,
   parameter int LAT_W     = 8,
   parameter int SMALL_TOT = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NPIX-1:0]       disc_i,
   output logic                  store_o,
   output logic [NPIX*TOT_W-1:0] tot_o,
   output logic [LAT_W-1:0]      age_o
);
   localparam logic [LAT_W-1:0] AGE_MAX = {LAT_W{1'b1}};

   logic [NPIX-1:0]  join_v, run_v, end_v, mem_v, big_v;
   logic [TOT_W-1:0] tot_a [NPIX];
   logic             open_q;
   logic [LAT_W-1:0] age_q;
   logic             close;

   for (genvar p = 0; p < NPIX; p++) begin : g_pix
      pixreg_tot_meas #(.TOT_W(TOT_W)) meas_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .disc_i    (disc_i[p]),
         .close_i   (close),
         .join_o    (join_v[p]),
         .running_o (run_v[p]),
         .ends_o    (end_v[p]),
         .joined_o  (mem_v[p]),
         .tot_o     (tot_a[p])
      );
      assign big_v[p] = mem_v[p] && (32'(tot_a[p]) >= SMALL_TOT);
      assign tot_o[p*TOT_W +: TOT_W] = mem_v[p] ? tot_a[p] : '0;
   end

   assign close   = open_q && (join_v == '0) && ((run_v & ~end_v) == '0);
   assign store_o = close && (big_v != '0);
   assign age_o   = (age_q == AGE_MAX) ? age_q : age_q + LAT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         age_q  <= '0;
      end else if (!open_q) begin
         if (join_v != '0) begin
            open_q <= 1'b1;
            age_q  <= LAT_W'(1);
         end
      end else begin
         age_q <= age_o;
         if (close) open_q <= 1'b0;
      end
   end

   // R2: an event opens only on a leading edge
   assert_open_on_edge_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_q) |-> $past(join_v != '0));
endmodule

// File: rtl/pixreg_slot_pool.sv
module pixreg_slot_pool
   import pixreg_pkg::*;
#(
   parameter int NSLOT  = 5,
   parameter int DATA_W = 16,
   parameter int LAT_W  = 8,
   parameter int TAG_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              store_i,
   input  logic [DATA_W-1:0] store_tot_i,
   input  logic [LAT_W-1:0]  store_age_i,
   input  logic [LAT_W-1:0]  latency_i,
   input  logic              trig_i,
   input  logic [TAG_W-1:0]  trig_tag_i,
   input  logic              token_in_i,
   input  logic              read_i,
   output logic              token_out_o,
   output logic              data_valid_o,
   output logic [DATA_W-1:0] data_tot_o,
   output logic [TAG_W-1:0]  data_tag_o,
   output logic              overflow_o
);
   slot_state_e       st_q  [NSLOT];
   logic [LAT_W-1:0]  cnt_q [NSLOT];
   logic [DATA_W-1:0] tot_q [NSLOT];
   logic [TAG_W-1:0]  tag_q [NSLOT];
   logic [NSLOT-1:0]  free_v, trig_v, alloc_sel, rd_sel;
   logic              any_free, any_trig, ovf_q;

   for (genvar s = 0; s < NSLOT; s++) begin : g_flags
      assign free_v[s] = (st_q[s] == SLOT_FREE);
      assign trig_v[s] = (st_q[s] == SLOT_TRIG);
   end

   assign any_free = (free_v != '0);
   assign any_trig = (trig_v != '0);

   always_comb begin
      alloc_sel = '0;
      rd_sel    = '0;
      for (int s = NSLOT - 1; s >= 0; s--) begin
         if (free_v[s]) alloc_sel = NSLOT'(1) << s;
         if (trig_v[s]) rd_sel    = NSLOT'(1) << s;
      end
   end

   always_comb begin
      data_tot_o = '0;
      data_tag_o = '0;
      for (int s = 0; s < NSLOT; s++) begin
         if (rd_sel[s]) begin
            data_tot_o = tot_q[s];
            data_tag_o = tag_q[s];
         end
      end
   end

   assign data_valid_o = token_in_i & any_trig;
   assign token_out_o  = token_in_i & ~any_trig;
   assign overflow_o   = ovf_q;

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic take, drop;
      assign take = store_i & alloc_sel[s];
      assign drop = read_i & data_valid_o & rd_sel[s];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q[s]  <= SLOT_FREE;
            cnt_q[s] <= '0;
            tot_q[s] <= '0;
            tag_q[s] <= '0;
         end else if (take) begin
            st_q[s]  <= SLOT_WAIT;
            cnt_q[s] <= store_age_i;
            tot_q[s] <= store_tot_i;
         end else begin
            case (st_q[s])
               SLOT_WAIT: begin
                  if (cnt_q[s] == latency_i) begin
                     if (trig_i) begin
                        st_q[s]  <= SLOT_TRIG;
                        tag_q[s] <= trig_tag_i;
                     end else begin
                        st_q[s] <= SLOT_FREE;
                     end
                  end else if (cnt_q[s] > latency_i) begin
                     st_q[s] <= SLOT_FREE;
                  end else begin
                     cnt_q[s] <= cnt_q[s] + LAT_W'(1);
                  end
               end
               SLOT_TRIG: if (drop) st_q[s] <= SLOT_FREE;
               default: ;
            endcase
         end
      end

      // R4: a slot becomes triggered only under a trigger strobe
      assert_trig_needs_strobe_R4 : assert property (@(posedge clk) disable iff (!rst_n)
         (st_q[s] == SLOT_TRIG && !$past(st_q[s] == SLOT_TRIG)) |-> $past(trig_i));
      // R5: a waiting slot ages by one per cycle
      assert_latency_step_R5 : assert property (@(posedge clk) disable iff (!rst_n)
         (st_q[s] == SLOT_WAIT && $past(st_q[s] == SLOT_WAIT)) |-> cnt_q[s] == $past(cnt_q[s]) + LAT_W'(1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ovf_q <= 1'b0;
      else        ovf_q <= store_i & ~any_free;
   end

   // R6: overflow is raised only when the pool was full
   assert_no_overflow_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      overflow_o |-> $past(free_v == '0));
   // R8: a read removes exactly one triggered slot
   assert_read_frees_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(read_i && data_valid_o) && !$past(store_i)) |-> $countones(trig_v) < $past($countones(trig_v)));
endmodule

// File: rtl/pixreg_hit_buffer.sv
module pixreg_hit_buffer
   import pixreg_pkg::*;
#(
   parameter int NSLOT     = 5,
   parameter int TOT_W     = 4,
   parameter int LAT_W     = 8,
   parameter int TAG_W     = 4,
   parameter int SMALL_TOT = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [3:0]            disc_i,
   input  logic [LAT_W-1:0]      latency_i,
   input  logic                  trig_i,
   input  logic [TAG_W-1:0]      trig_tag_i,
   input  logic                  token_in_i,
   input  logic                  read_i,
   output logic                  token_out_o,
   output logic                  data_valid_o,
   output logic [4*TOT_W-1:0]    data_tot_o,
   output logic [TAG_W-1:0]      data_tag_o,
   output logic                  overflow_o
);
   localparam int DATA_W = NPIX * TOT_W;

   if (NSLOT < 1) begin : g_bad_slots
      $error("pixreg_hit_buffer: NSLOT must be at least 1");
   end
   if (TOT_W < 2) begin : g_bad_tot
      $error("pixreg_hit_buffer: TOT_W must be at least 2");
   end
   if (SMALL_TOT < 1 || SMALL_TOT >= (1 << TOT_W)) begin : g_bad_small
      $error("pixreg_hit_buffer: SMALL_TOT out of ToT range");
   end
   if (LAT_W < 2 || TAG_W < 1) begin : g_bad_widths
      $error("pixreg_hit_buffer: LAT_W or TAG_W too small");
   end

   logic              store;
   logic [DATA_W-1:0] store_tot;
   logic [LAT_W-1:0]  store_age;

   pixreg_event_track #(
      .TOT_W     (TOT_W),
      .LAT_W     (LAT_W),
      .SMALL_TOT (SMALL_TOT)
   ) track_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .disc_i  (disc_i),
      .store_o (store),
      .tot_o   (store_tot),
      .age_o   (store_age)
   );

   pixreg_slot_pool #(
      .NSLOT  (NSLOT),
      .DATA_W (DATA_W),
      .LAT_W  (LAT_W),
      .TAG_W  (TAG_W)
   ) pool_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .store_i      (store),
      .store_tot_i  (store_tot),
      .store_age_i  (store_age),
      .latency_i    (latency_i),
      .trig_i       (trig_i),
      .trig_tag_i   (trig_tag_i),
      .token_in_i   (token_in_i),
      .read_i       (read_i),
      .token_out_o  (token_out_o),
      .data_valid_o (data_valid_o),
      .data_tot_o   (data_tot_o),
      .data_tag_o   (data_tag_o),
      .overflow_o   (overflow_o)
   );

   // R7: the token is never passed on while an event is being presented
   assert_token_exclusive_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !(token_out_o && data_valid_o));
endmodule

// File: tb/pixreg_hit_buffer_tb_top.sv
`timescale 1ns/100ps
module pixreg_hit_buffer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  disc_i;
   logic [7:0]  latency_i;
   logic        trig_i;
   logic [3:0]  trig_tag_i;
   logic        token_in_i;
   logic        read_i;
   logic        token_out_o, data_valid_o, overflow_o;
   logic [15:0] data_tot_o;
   logic [3:0]  data_tag_o;

   int errors = 0;
   int checks = 0;
   logic ovf_seen;

   always #2.5 clk = ~clk;

   pixreg_hit_buffer dut_i (
      .clk(clk), .rst_n(rst_n), .disc_i(disc_i), .latency_i(latency_i),
      .trig_i(trig_i), .trig_tag_i(trig_tag_i), .token_in_i(token_in_i),
      .read_i(read_i), .token_out_o(token_out_o), .data_valid_o(data_valid_o),
      .data_tot_o(data_tot_o), .data_tag_o(data_tag_o), .overflow_o(overflow_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // offs/wids: one byte per pixel, pixel 0 in the low byte; width 0 = no hit
   task automatic run_event(input logic [31:0] offs, input logic [31:0] wids,
                            input bit do_trig, input int trig_at, input logic [3:0] tag);
      for (int t = 0; t <= int'(latency_i); t++) begin
         @(negedge clk);
         if (overflow_o) ovf_seen = 1'b1;
         for (int p = 0; p < 4; p++) begin
            int o, w;
            o = int'(offs[p*8 +: 8]);
            w = int'(wids[p*8 +: 8]);
            disc_i[p] = (w > 0) && (t >= o) && (t < o + w);
         end
         trig_i     = do_trig && (t == trig_at);
         trig_tag_i = tag;
      end
      @(negedge clk);
      if (overflow_o) ovf_seen = 1'b1;
      disc_i = '0;
      trig_i = 1'b0;
   endtask

   task automatic read_one();
      read_i = 1'b1;
      @(negedge clk);
      read_i = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R9 valid after reset", 32'(data_valid_o), 0);
      check("R9 overflow after reset", 32'(overflow_o), 0);
      check("R9 token passes after reset", 32'(token_out_o), 1);
   endtask

   task automatic t_single();
      run_event(32'h0, 32'h0000_0005, 1, 24, 4'hA);
      check("R1 single upper-left ToT", 32'(data_tot_o), 32'h0005);
      check("R4 triggered valid", 32'(data_valid_o), 1);
      check("R4 tag captured", 32'(data_tag_o), 32'hA);
      check("R7 token held", 32'(token_out_o), 0);
      read_one();
      check("R8 slot freed by read", 32'(data_valid_o), 0);
      check("R7 token released", 32'(token_out_o), 1);
   endtask

   task automatic t_four_sat();
      run_event(32'h0000_0000, 32'h1106_0504, 1, 24, 4'h3);
      check("R1 four pixels and saturation", 32'(data_tot_o), 32'hF654);
      check("R1 tag", 32'(data_tag_o), 32'h3);
      read_one();
   endtask

   task automatic t_assoc();
      run_event(32'h0300_0000, 32'h0100_0008, 1, 24, 4'h5);
      check("R3 small neighbour kept", 32'(data_tot_o), 32'h1008);
      check("R2 joined in one event", 32'(data_valid_o), 1);
      read_one();
      check("R2 single event only", 32'(data_valid_o), 0);
      // second pixel starts after the first closed: separate event
      run_event(32'h0006_0000, 32'h0006_0004, 1, 24, 4'h6);
      check("R2 late pixel separate event", 32'(data_tot_o), 32'h0004);
      read_one();
      idle(10);
      check("R5 later event expired untriggered", 32'(data_valid_o), 0);
   endtask

   task automatic t_small();
      run_event(32'h0, 32'h0000_0002, 1, 24, 4'h1);
      check("R3 small-only dropped", 32'(data_valid_o), 0);
      run_event(32'h0, 32'h0000_0003, 1, 24, 4'h2);
      check("R3 threshold hit kept", 32'(data_valid_o), 1);
      check("R3 threshold ToT", 32'(data_tot_o), 32'h0003);
      read_one();
   endtask

   task automatic t_miss();
      run_event(32'h0, 32'h0000_0005, 1, 23, 4'h7);
      check("R5 early trigger ignored", 32'(data_valid_o), 0);
      run_event(32'h0, 32'h0000_0005, 0, 0, 4'h7);
      check("R5 no trigger released", 32'(data_valid_o), 0);
   endtask

   task automatic t_latency();
      latency_i = 8'd40;
      run_event(32'h0, 32'h0000_0700, 1, 40, 4'h9);
      check("R4 latency 40 triggered", 32'(data_valid_o), 1);
      check("R4 latency 40 ToT", 32'(data_tot_o), 32'h0070);
      read_one();
      latency_i = 8'd24;
   endtask

   task automatic t_token();
      token_in_i = 1'b0;
      run_event(32'h0, 32'h0000_0004, 1, 24, 4'hC);
      check("R7 no token no valid", 32'(data_valid_o), 0);
      check("R7 no token passed", 32'(token_out_o), 0);
      read_i = 1'b1;
      @(negedge clk);
      read_i = 1'b0;
      token_in_i = 1'b1;
      #0.1;
      check("R7 token arrives valid", 32'(data_valid_o), 1);
      check("R8 read without token ignored", 32'(data_tag_o), 32'hC);
      read_one();
   endtask

   task automatic t_overflow();
      ovf_seen = 1'b0;
      for (int e = 0; e < 5; e++) begin
         run_event(32'h0, 32'h0000_0004, 1, 24, 4'(e));
      end
      check("R6 no overflow with five", 32'(ovf_seen), 0);
      run_event(32'h0, 32'h0000_0004, 1, 24, 4'hE);
      check("R6 sixth event overflows", 32'(ovf_seen), 1);
      for (int e = 0; e < 5; e++) begin
         check("R8 readout order", 32'(data_tag_o), 32'(e));
         read_one();
      end
      check("R6 dropped event absent", 32'(data_valid_o), 0);
   endtask

   initial begin
      rst_n = 1'b0; disc_i = '0; latency_i = 8'd24; trig_i = 1'b0;
      trig_tag_i = '0; token_in_i = 1'b1; read_i = 1'b0; ovf_seen = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_single();
      t_four_sat();
      t_assoc();
      t_small();
      t_miss();
      t_latency();
      t_token();
      t_overflow();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #900000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule